// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an 8-bit up-counter with a small register port. A two-bit mode field selects what advances it. In timer mode it counts an internal time base, taken from either the system clock divided by four or a slow oscillator input. That base passes through a power-of-two prescaler. In event mode it counts edges on an external pin, with no prescaling. In capture mode it counts the prescaled time base only while a pulse on the external pin is in progress. The pulse is bounded by a programmable start edge and stop edge.

When the counter is full and is told to advance, it reloads from a preload register and keeps running. It also sets a sticky overflow flag and, if the interrupt enable input is high, raises a one-cycle interrupt pulse. Software programs the block through a write port and reads it back through a combinational read port. Both asynchronous inputs, the pin and the slow oscillator, pass through a two-flop synchroniser before their edges are detected.

Top module: `mode_timer`

## Requirements
- R1: Register address 0 is the control register. Bits 7:6 are the mode: 00 idle, 01 event, 10 timer, 11 capture. Bit 5 is the clock source, bit 4 is run, bit 3 is edge select, and bits 2:0 always read 0. Every register resets to zero. In idle mode the counter holds even when run is 1.
- R2: In timer mode with source 0, and with P held in bits 2:0 of register address 1, the counter advances once every 4·2^P system clocks. The first increment falls on the 4·2^P-th rising clock edge after the edge that applies the control write.
- R3: In timer mode with source 1, the counter advances once for every 2^P falling edges of the synchronised slow oscillator input.
- R4: The counter changes by at most one per cycle. While run is 0 it changes only through a preload load.
- R5: In event mode, edge select 0 counts rising edges of the pin and edge select 1 counts falling edges. The prescaler is not applied. An edge driven before clock edge k shows up in the counter after clock edge k+2.
- R6: A count step taken while the counter holds 0xFF loads the preload value instead, and counting goes on from there.
- R7: In capture mode with edge select 0, the prescaled time base is counted from a falling pin edge until the next rising edge. With edge select 1 the polarity is reversed. If the block is enabled while a pulse is already in progress, nothing is counted until the next start edge.
- R8: Each overflow drives the interrupt output high for exactly one cycle, and only when the interrupt enable input is high. When that input is low, the reload and the flag still take place.
- R9: Bit 0 of register address 4 is a sticky overflow flag. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R10: Register address 2 holds the preload value. A write to it while run is 0 also loads the counter. A write while run is 1 leaves the counter alone.
- R11: Register address 3 reads the counter. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| slow_clk | input | 1 | Slow oscillator level, asynchronous |
| ext_pin | input | 1 | External event or pulse input, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench sweeps the prescaler settings and samples one cycle before and one cycle after each expected count step. A divider that starts out of phase, or a prescaler mask that is off by one, moves the step by a cycle and is caught there.

The overflow check sits on the cycle of the 0xFF-to-reload transition. It would catch a design that wraps to zero or that fires the interrupt while the enable input is low. Event tests probe the exact edge latency, confirm that the prescaler has no effect, and confirm that the opposite edge is ignored.

Capture runs use pulse windows whose expected counts come from the tick phase. One run enables the block in the middle of a pulse, which exposes a design that uses the pin level as the gate instead of the start and stop edges.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_TIMER   = 2'b10,
        MODE_CAPTURE = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  src;
        logic  on;
        logic  edge_sel;
    } ctrl_t;

    localparam int A_CTRL = 0;
    localparam int A_PSC  = 1;
    localparam int A_PRE  = 2;
    localparam int A_CNT  = 3;
    localparam int A_STAT = 4;

endpackage

// File: rtl/mtmr_sync.sv
module mtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic prev_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = chain_q[STAGES];
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PSC_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [CNT_W-1:0]  pre_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              flag_clr_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [PSC_W-1:0]  psc;
        logic [CNT_W-1:0]  pre;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d      = reg_q;
        load_o     = 1'b0;
        flag_clr_o = 1'b0;
        load_val_o = wr_data;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_CTRL): begin
                    reg_d.ctrl.mode     = mode_e'(wr_data[7:6]);
                    reg_d.ctrl.src      = wr_data[5];
                    reg_d.ctrl.on       = wr_data[4];
                    reg_d.ctrl.edge_sel = wr_data[3];
                end
                ADDR_W'(A_PSC): begin
                    reg_d.psc = wr_data[PSC_W-1:0];
                end
                ADDR_W'(A_PRE): begin
                    reg_d.pre = wr_data;
                    // a stopped counter follows the preload write
                    load_o    = !reg_q.ctrl.on;
                end
                ADDR_W'(A_STAT): begin
                    flag_clr_o = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign ctrl_o = reg_q.ctrl;
    assign psc_o  = reg_q.psc;
    assign pre_o  = reg_q.pre;
endmodule

// File: rtl/mtmr_tick_gen.sv
module mtmr_tick_gen #(
    parameter int PSC_W    = 3,
    parameter int SYSDIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             src_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             slow_lvl_i,
    input  logic             slow_prev_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [SYSDIV_W-1:0] div;
        logic [PRE_W-1:0]    pre;
    } tick_t;

    tick_t st_d, st_q;
    logic             base_tick;
    logic [PRE_W-1:0] pre_mask;

    always_comb begin
        st_d      = st_q;
        // divided system clock falls as the divider wraps; slow clock on its falling edge
        base_tick = src_i ? (slow_prev_i && !slow_lvl_i) : (st_q.div == '1);
        pre_mask  = PRE_W'((1 << psc_i) - 1);
        tick_o    = run_i && base_tick && ((st_q.pre & pre_mask) == pre_mask);
        if (!run_i) begin
            st_d.div = '0;
            st_d.pre = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
            if (base_tick) st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] pre_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             flag_clr_i,
    input  logic             pin_lvl_i,
    input  logic             pin_prev_i,
    input  logic             tick_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             active;
        logic             irq;
    } core_t;

    core_t st_d, st_q;
    logic pin_rise, pin_fall, start_edge, stop_edge, step, wrap;

    always_comb begin
        st_d       = st_q;
        pin_rise   = pin_lvl_i && !pin_prev_i;
        pin_fall   = !pin_lvl_i && pin_prev_i;
        start_edge = ctrl_i.edge_sel ? pin_rise : pin_fall;
        stop_edge  = ctrl_i.edge_sel ? pin_fall : pin_rise;

        case (ctrl_i.mode)
            MODE_EVENT:   step = ctrl_i.on && (ctrl_i.edge_sel ? pin_fall : pin_rise);
            MODE_TIMER:   step = tick_i;
            MODE_CAPTURE: step = tick_i && st_q.active;
            default:      step = 1'b0;
        endcase
        wrap = step && (st_q.cnt == '1);

        if (ctrl_i.mode != MODE_CAPTURE || !ctrl_i.on) st_d.active = 1'b0;
        else if (start_edge)                           st_d.active = 1'b1;
        else if (stop_edge)                            st_d.active = 1'b0;

        if (load_i)    st_d.cnt = load_val_i;
        else if (wrap) st_d.cnt = pre_i;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;

        if (wrap)            st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;

        st_d.irq = wrap && irq_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 3,
    parameter int ADDR_W      = 3,
    parameter int SYSDIV_W    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              slow_clk,
    input  logic              ext_pin,
    input  logic              irq_en,
    output logic              irq
);
    localparam int N_ASYNC  = 2;
    localparam int IDX_PIN  = 0;
    localparam int IDX_SLOW = 1;

    ctrl_t             ctrl_w;
    logic [PSC_W-1:0]  psc_w;
    logic [CNT_W-1:0]  pre_w, cnt_w, load_val_w;
    logic              load_w, flag_clr_w, flag_w, tick_w, run_w;
    logic [N_ASYNC-1:0] async_in, sync_lvl, sync_prev;

    assign async_in[IDX_PIN]  = ext_pin;
    assign async_in[IDX_SLOW] = slow_clk;

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        mtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (async_in[g]),
            .level_o (sync_lvl[g]),
            .prev_o  (sync_prev[g])
        );
    end

    mtmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctrl_o     (ctrl_w),
        .psc_o      (psc_w),
        .pre_o      (pre_w),
        .load_o     (load_w),
        .load_val_o (load_val_w),
        .flag_clr_o (flag_clr_w)
    );

    assign run_w = ctrl_w.on &&
                   (ctrl_w.mode == MODE_TIMER || ctrl_w.mode == MODE_CAPTURE);

    mtmr_tick_gen #(.PSC_W(PSC_W), .SYSDIV_W(SYSDIV_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_w),
        .src_i       (ctrl_w.src),
        .psc_i       (psc_w),
        .slow_lvl_i  (sync_lvl[IDX_SLOW]),
        .slow_prev_i (sync_prev[IDX_SLOW]),
        .tick_o      (tick_w)
    );

    mtmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_w),
        .pre_i      (pre_w),
        .load_i     (load_w),
        .load_val_i (load_val_w),
        .flag_clr_i (flag_clr_w),
        .pin_lvl_i  (sync_lvl[IDX_PIN]),
        .pin_prev_i (sync_prev[IDX_PIN]),
        .tick_i     (tick_w),
        .irq_en_i   (irq_en),
        .cnt_o      (cnt_w),
        .flag_o     (flag_w),
        .irq_o      (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL): rd_data[7:3] = {ctrl_w.mode, ctrl_w.src, ctrl_w.on, ctrl_w.edge_sel};
            ADDR_W'(A_PSC):  rd_data[PSC_W-1:0] = psc_w;
            ADDR_W'(A_PRE):  rd_data = pre_w;
            ADDR_W'(A_CNT):  rd_data = cnt_w;
            ADDR_W'(A_STAT): rd_data[0] = flag_w;
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker
    import mtmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_data,
    input logic              irq,
    input logic              irq_en,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic [CNT_W-1:0]  preload,
    input logic              load,
    input mode_e             mode,
    input logic              run
);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && !load) |=> $stable(cnt));

    p_ctrl_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(A_CTRL)) |-> (rd_data[2:0] == 3'b000));

    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && mode != MODE_EVENT && !load) |=> $stable(cnt));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '1) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '1) |=> (cnt == '1 || cnt == $past(preload)));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind mode_timer mtmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .irq_en  (irq_en),
    .cnt     (cnt_w),
    .flag    (flag_w),
    .preload (pre_w),
    .load    (load_w),
    .mode    (ctrl_w.mode),
    .run     (ctrl_w.on)
);

// File: tb/mode_timer_tb.sv
module mode_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       slow_clk = 1'b0;
    logic       ext_pin = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;

    always #10 clk = ~clk;

    mode_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .slow_clk(slow_clk), .ext_pin(ext_pin),
        .irq_en(irq_en), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[7:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = a[2:0];
        #1 v = int'(rd_data);
    endtask

    task automatic setup(input int psc, input int pre);
        wr(0, 0);
        wr(1, psc);
        wr(2, pre);
    endtask

    task automatic slow_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            slow_clk = 1'b1; cyc(5);
            slow_clk = 1'b0; cyc(5);
        end
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = ~ext_pin; cyc(3);
            ext_pin = ~ext_pin; cyc(3);
        end
    endtask

    // ticks of the /4 base at edges 4k; capture gate open for edges a+3 .. b+2
    function automatic int cap_exp(input int a, input int b);
        int n = 0;
        for (int j = a + 3; j <= b + 2; j++) if (j % 4 == 0) n++;
        return n;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v, v0, per, s, a, b;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(0, v); chk("R1 ctrl reset", v, 0);
        rd(1, v); chk("R1 psc reset", v, 0);
        rd(2, v); chk("R10 preload reset", v, 0);
        rd(3, v); chk("R11 count reset", v, 0);
        rd(4, v); chk("R9 flag reset", v, 0);
        chk("R8 irq reset", int'(irq), 0);

        // R1 control readback, low bits zero
        wr(0, 8'hFF);
        rd(0, v); chk("R1 ctrl readback", v, 8'hF8);

        // R1 idle mode holds with run set
        setup(0, 7);
        rd(3, v); chk("R10 load while stopped", v, 7);
        wr(0, 8'h10);
        pin_pulses(4);
        slow_pulses(3);
        cyc(20);
        rd(3, v); chk("R1 idle hold", v, 7);

        // R2 timer sweep over prescaler, source = system clock / 4
        for (int p = 0; p < 4; p++) begin
            setup(p, 0);
            wr(0, 8'h90);
            per = 4 << p;
            cyc(3 * per - 1);
            rd(3, v); chk($sformatf("R2 p=%0d before step", p), v, 2);
            cyc(1);
            rd(3, v); chk($sformatf("R2 p=%0d at step", p), v, 3);
        end

        // R4 stop holds the count
        wr(0, 8'h80);
        rd(3, v0);
        cyc(100);
        rd(3, v); chk("R4 stopped hold", v, v0);

        // R3 slow oscillator source
        setup(0, 0);
        wr(0, 8'hB0);
        slow_pulses(6);
        cyc(3);
        rd(3, v); chk("R3 slow p=0", v, 6);
        setup(2, 0);
        wr(0, 8'hB0);
        slow_pulses(10);
        cyc(3);
        rd(3, v); chk("R3 slow p=2", v, 2);

        // R6 R8 R9 overflow with interrupt enabled
        setup(0, 8'hF0);
        irq_en = 1'b1;
        wr(0, 8'h90);
        cyc(63);
        rd(3, v); chk("R6 full before wrap", v, 8'hFF);
        chk("R8 irq low before wrap", int'(irq), 0);
        cyc(1);
        rd(3, v); chk("R6 reload value", v, 8'hF0);
        chk("R8 irq pulse", int'(irq), 1);
        rd(4, v); chk("R9 flag set", v, 1);
        cyc(1);
        chk("R8 irq one cycle", int'(irq), 0);

        // R8 interrupt masked, reload still happens
        irq_en = 1'b0;
        irq_seen = 0;
        cyc(70);
        chk("R8 masked irq", irq_seen, 0);
        rd(3, v); chk("R6 reload while masked", v, 8'hF1);

        // R9 flag clear semantics
        wr(4, 0);
        rd(4, v); chk("R9 write 0 keeps flag", v, 1);
        wr(4, 1);
        rd(4, v); chk("R9 write 1 clears flag", v, 0);

        // R10 R11 preload and counter writes
        setup(7, 8'h10);
        wr(0, 8'h90);
        wr(2, 8'h33);
        rd(3, v); chk("R10 running preload keeps count", v, 8'h10);
        rd(2, v); chk("R10 preload readback", v, 8'h33);
        wr(3, 8'h55);
        rd(3, v); chk("R11 count write ignored", v, 8'h10);
        wr(0, 0);
        wr(3, 8'h55);
        rd(3, v); chk("R11 count write ignored stopped", v, 8'h10);

        // R5 event mode rising edges, prescaler set but bypassed
        ext_pin = 1'b0;
        setup(3, 0);
        cyc(4);
        wr(0, 8'h50);
        ext_pin = 1'b1;
        cyc(2);
        rd(3, v); chk("R5 rise latency before", v, 0);
        cyc(1);
        rd(3, v); chk("R5 rise latency after", v, 1);
        ext_pin = 1'b0;
        cyc(5);
        rd(3, v); chk("R5 fall ignored", v, 1);
        pin_pulses(7);
        cyc(3);
        rd(3, v); chk("R5 rising count", v, 8);

        // R5 falling edges
        setup(3, 0);
        wr(0, 8'h58);
        ext_pin = 1'b1;
        cyc(5);
        rd(3, v); chk("R5 rise ignored", v, 0);
        ext_pin = 1'b0;
        cyc(2);
        rd(3, v); chk("R5 fall latency before", v, 0);
        cyc(1);
        rd(3, v); chk("R5 fall latency after", v, 1);
        pin_pulses(7);
        cyc(3);
        rd(3, v); chk("R5 falling count", v, 8);

        // R7 capture, edge select 0: low pulse
        setup(0, 0);
        ext_pin = 1'b1;
        cyc(4);
        wr(0, 8'hD0);
        s = 5;
        cyc(s);
        ext_pin = 1'b0; a = s + 1;
        cyc(23);
        ext_pin = 1'b1; b = s + 23 + 1;
        cyc(12);
        rd(3, v); chk("R7 low pulse", v, cap_exp(a, b));
        v0 = v;
        cyc(20);
        rd(3, v); chk("R7 stopped after pulse", v, v0);

        // R7 capture, edge select 0, longer pulse at another phase
        setup(0, 0);
        cyc(4);
        wr(0, 8'hD0);
        s = 2;
        cyc(s);
        ext_pin = 1'b0; a = s + 1;
        cyc(40);
        ext_pin = 1'b1; b = s + 40 + 1;
        cyc(12);
        rd(3, v); chk("R7 long low pulse", v, cap_exp(a, b));

        // R7 capture, edge select 1: high pulse
        setup(0, 0);
        ext_pin = 1'b0;
        cyc(4);
        wr(0, 8'hD8);
        s = 3;
        cyc(s);
        ext_pin = 1'b1; a = s + 1;
        cyc(17);
        ext_pin = 1'b0; b = s + 17 + 1;
        cyc(12);
        rd(3, v); chk("R7 high pulse", v, cap_exp(a, b));

        // R7 enabled in the middle of a pulse
        setup(0, 0);
        ext_pin = 1'b0;
        cyc(4);
        wr(0, 8'hD0);
        cyc(30);
        rd(3, v); chk("R7 mid-pulse no count", v, 0);
        ext_pin = 1'b1;
        cyc(20);
        rd(3, v); chk("R7 stop edge alone", v, 0);
        ext_pin = 1'b0; a = 51;
        cyc(16);
        ext_pin = 1'b1; b = 67;
        cyc(12);
        rd(3, v); chk("R7 pulse after mid-pulse enable", v, cap_exp(a, b));

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule